// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block behaves as a small byte-addressed serial EEPROM attached to a two-wire (I2C) bus. It runs on a system clock and oversamples the clock and data lines through synchronizers. It detects start, repeated start and stop conditions, matches its control byte and drives the data line only through an open-drain output enable. Write data go into a one-page buffer. The array is updated only when a stop ends the write command. A self-timed busy period then follows, and during it the block refuses every control byte so that a master can poll for completion.

Reads come in three forms. A current-address read uses the pointer left by the previous access. A random read loads the pointer through a write command that carries no data, and a read control byte follows a repeated start. A sequential read continues for as long as the master acknowledges. A write-protect input makes the whole array read-only. The array has 512 bytes, and the block bit of the control byte supplies address bit 8.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The control byte is `1010`, then two select bits, then the block bit, then R/W (bit 0; 0 = write, 1 = read). It is acknowledged only when the upper nibble is `1010` and the two select bits equal `sel_i`. Any other control byte gets no acknowledge, and the block stays silent until the next start.
- R2: In a write command, the byte after the control byte is the word address. The pointer becomes {block bit, word address}. The word address and every data byte are acknowledged, and data bytes go into the page buffer.
- R3: The array is updated only when a stop follows write data. When a repeated start follows write data, the buffered bytes are discarded, the stored contents stay unchanged and no busy period begins.
- R4: After a committing stop, the block is busy for `WRITE_CYCLES` system clocks. During that time it acknowledges no control byte, whether write or read.
- R5: Once the busy period ends, a write control byte is acknowledged again, and the committed bytes read back.
- R6: During a write, the pointer advances within the 16-byte page and wraps from the last byte of the page to the first byte of the same page.
- R7: During a read, the pointer wraps from address 511 to address 0.
- R8: A current-address read returns the byte at the last accessed address plus one. The pointer keeps that value across transactions until reset.
- R9: A random read (word address write, repeated start, read control byte) returns the byte at the loaded address.
- R10: After a data byte, a master acknowledge continues the read with the next address. A master non-acknowledge ends the read, and the block releases the data line.
- R11: With `wp_i` high, write bytes are still acknowledged, but nothing is committed and no busy period follows.
- R12: After reset the data line is released and the first control byte is acknowledged. The block changes its data-line drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| wp_i | input | 1 | Write protect; high makes the array read-only |
| sel_i | input | 2 - BLOCK_BITS + 1 | Strap value compared with the control byte's select bits |

## Verification
The hardest state to reach from the ports is a write buffer that holds data when a repeated start arrives with no stop in between. That case must leave the array untouched and start no busy period. The bench builds this sequence from its bit-level bus tasks. It writes one byte to a location with a known value, issues a repeated start, and makes a random read of the same location inside the same transaction. It then confirms that the next control byte is acknowledged at once and that a fresh read still returns the old value. The busy window is reached in a similar way: a read control byte and a write control byte are sent straight after a committing stop, well inside a short `WRITE_CYCLES` setting.

// File: rtl/ee_pkg.sv
package ee_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_WADR,
    ST_ACK_WADR,
    ST_WDAT,
    ST_ACK_WDAT,
    ST_RDAT,
    ST_RACK
  } ee_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  // one extra stage past the synchronizer keeps the previous sample
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_c, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_c     = scl_sh[STAGES-1];
  assign scl_p     = scl_sh[STAGES];
  assign sda_s     = sda_sh[STAGES-1];
  assign sda_p     = sda_sh[STAGES];
  assign scl_rise  = scl_c & ~scl_p;
  assign scl_fall  = ~scl_c & scl_p;
  assign start_det = scl_c & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_c & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (kick)             cnt_d = CW'(CYCLES);
    else if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import ee_pkg::*;
#(
  parameter int BLOCK_BITS   = 1,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 5000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic                  wp_i,
  input  logic [2-BLOCK_BITS:0] sel_i
);

  localparam int AW        = 8 + BLOCK_BITS;
  localparam int MEM_BYTES = 1 << AW;
  localparam int PW        = $clog2(PAGE_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit;

  ee_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ee_wr_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .kick(commit), .busy(busy)
  );

  ee_state_e             st_q, st_d;
  logic [3:0]            bit_q, bit_d;
  logic [7:0]            sh_q, sh_d;
  logic [7:0]            rd_q, rd_d;
  logic                  oe_q, oe_d;
  logic                  rw_q, rw_d;
  logic [BLOCK_BITS-1:0] blk_q, blk_d;
  logic [AW-1:0]         ptr_q, ptr_d;
  logic [PAGE_BYTES-1:0] bval_q, bval_d;
  logic                  buf_we;
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [7:0]            mem  [MEM_BYTES];

  assign commit = stop_det && (bval_q != '0) && !wp_i;

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rd_d   = rd_q;
    oe_d   = oe_q;
    rw_d   = rw_q;
    blk_d  = blk_q;
    ptr_d  = ptr_q;
    bval_d = bval_q;
    buf_we = 1'b0;
    if (start_det) begin
      st_d   = ST_DEV;
      bit_d  = 4'd0;
      oe_d   = 1'b0;
      bval_d = '0;
    end else if (stop_det) begin
      st_d   = ST_IDLE;
      oe_d   = 1'b0;
      bval_d = '0;
    end else begin
      if (scl_rise && bit_q < 4'd8 &&
          (st_q == ST_DEV || st_q == ST_WADR || st_q == ST_WDAT)) begin
        sh_d  = {sh_q[6:0], sda_s};
        bit_d = bit_q + 4'd1;
      end
      if (scl_rise && st_q == ST_RACK && sda_s) st_d = ST_IDLE;
      if (scl_fall) begin
        unique case (st_q)
          ST_DEV: if (bit_q == 4'd8) begin
            if (sh_q[7:4] == DEV_CODE && sh_q[3:1+BLOCK_BITS] == sel_i && !busy) begin
              oe_d  = 1'b1;
              rw_d  = sh_q[0];
              blk_d = sh_q[BLOCK_BITS:1];
              st_d  = ST_ACK_DEV;
            end else begin
              st_d = ST_IDLE;
            end
          end
          ST_ACK_DEV: begin
            bit_d = 4'd0;
            if (rw_q) begin
              rd_d  = mem[ptr_q];
              oe_d  = ~mem[ptr_q][7];
              ptr_d = ptr_q + AW'(1);
              bit_d = 4'd1;
              st_d  = ST_RDAT;
            end else begin
              oe_d = 1'b0;
              st_d = ST_WADR;
            end
          end
          ST_WADR: if (bit_q == 4'd8) begin
            ptr_d = {blk_q, sh_q};
            oe_d  = 1'b1;
            st_d  = ST_ACK_WADR;
          end
          ST_WDAT: if (bit_q == 4'd8) begin
            buf_we                   = 1'b1;
            bval_d[ptr_q[PW-1:0]]    = 1'b1;
            ptr_d = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + PW'(1)};
            oe_d  = 1'b1;
            st_d  = ST_ACK_WDAT;
          end
          ST_ACK_WADR, ST_ACK_WDAT: begin
            oe_d  = 1'b0;
            bit_d = 4'd0;
            st_d  = ST_WDAT;
          end
          ST_RDAT: if (bit_q == 4'd8) begin
            oe_d = 1'b0;
            st_d = ST_RACK;
          end else begin
            oe_d  = ~rd_q[3'd7 - bit_q[2:0]];
            bit_d = bit_q + 4'd1;
          end
          ST_RACK: begin
            rd_d  = mem[ptr_q];
            oe_d  = ~mem[ptr_q][7];
            ptr_d = ptr_q + AW'(1);
            bit_d = 4'd1;
            st_d  = ST_RDAT;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= ST_IDLE;
      bit_q  <= 4'd0;
      sh_q   <= 8'd0;
      rd_q   <= 8'd0;
      oe_q   <= 1'b0;
      rw_q   <= 1'b0;
      blk_q  <= '0;
      ptr_q  <= '0;
      bval_q <= '0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      oe_q   <= oe_d;
      rw_q   <= rw_d;
      blk_q  <= blk_d;
      ptr_q  <= ptr_d;
      bval_q <= bval_d;
    end
  end

  // page buffer and array: storage without reset
  always_ff @(posedge clk) begin
    if (buf_we) pbuf[ptr_q[PW-1:0]] <= sh_q;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_commit
    always_ff @(posedge clk) begin
      if (commit && bval_q[g]) mem[{ptr_q[AW-1:PW], PW'(g)}] <= pbuf[g];
    end
  end

  assign sda_oe = oe_q;

endmodule

// File: rtl/ee_checker.sv
module ee_checker
  import ee_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        wp_i,
  input logic        sda_oe,
  input logic        busy,
  input ee_state_e   st,
  input logic [15:0] page
);

  assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  assert_busy_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_ACK_DEV |-> !busy);

  assert_wp_no_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i));

  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |-> !sda_oe);

  assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WDAT || st == ST_ACK_WDAT) &&
     ($past(st) == ST_WDAT || $past(st) == ST_ACK_WDAT)) |-> $stable(page));

endmodule

bind i2c_eeprom_target ee_checker u_chk (
  .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .wp_i(wp_i), .sda_oe(sda_oe),
  .busy(busy), .st(st_q), .page(16'(ptr_q >> PW))
);

// File: tb/sim_i2c_eeprom_target.sv
module sim_i2c_eeprom_target;

  localparam int H   = 10;
  localparam int WRC = 800;

  logic       clk, rst_n, scl, m_low, wp, sda_oe, sda_line;
  logic [1:0] sel;
  int n_chk, n_fail;
  bit done;

  assign sda_line = ~(m_low | sda_oe);

  i2c_eeprom_target #(.WRITE_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .wp_i(wp), .sel_i(sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {address[8:0], data[7:0]}
  localparam logic [16:0] VEC [6] = '{
    {9'h005, 8'h3C}, {9'h0A7, 8'hC1}, {9'h100, 8'h5A},
    {9'h1F3, 8'h0F}, {9'h07F, 8'hFF}, {9'h180, 8'h00}
  };

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrl(input logic blk, input logic rd);
    return {4'b1010, 2'b10, blk, rd};
  endfunction

  task automatic i2c_start;
    m_low = 0; hold(H); scl = 1; hold(H); m_low = 1; hold(H); scl = 0; hold(H);
  endtask

  task automatic i2c_stop;
    m_low = 1; hold(H); scl = 1; hold(H); m_low = 0; hold(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hold(H); scl = 1; hold(H); scl = 0;
    end
    m_low = 0; hold(H); scl = 1; hold(H/2); ack = ~sda_line; hold(H/2); scl = 0;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      hold(H); scl = 1; hold(H/2); d[i] = sda_line; hold(H/2); scl = 0;
    end
    m_low = mack; hold(H); scl = 1; hold(H); scl = 0; m_low = 0;
  endtask

  task automatic write_seq(input logic [8:0] a, input int n, input logic [31:0] dat,
                           output logic [5:0] acks);
    logic k;
    acks = '0;
    i2c_start;
    send_byte(ctrl(a[8], 1'b0), k); acks[0] = k;
    send_byte(a[7:0], k);           acks[1] = k;
    for (int j = 0; j < n; j++) begin
      send_byte(dat[31-8*j -: 8], k); acks[2+j] = k;
    end
    i2c_stop;
  endtask

  task automatic read_seq(input logic [8:0] a, input int n, output logic [31:0] d);
    logic k;
    logic [7:0] b;
    d = '0;
    i2c_start;
    send_byte(ctrl(a[8], 1'b0), k);
    send_byte(a[7:0], k);
    i2c_start;
    send_byte(ctrl(a[8], 1'b1), k);
    for (int j = 0; j < n; j++) begin
      read_byte(j != n - 1, b);
      d[31-8*j -: 8] = b;
    end
    i2c_stop;
  endtask

  task automatic poll(output int tries);
    logic k;
    tries = 0;
    for (int j = 0; j < 40; j++) begin
      i2c_start; send_byte(ctrl(1'b0, 1'b0), k); i2c_stop;
      if (k) break;
      tries++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all-requirements actual hung expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0]  acks;
    logic [31:0] d;
    logic [7:0]  b;
    logic        k;
    int          tries;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 0; scl = 1; m_low = 0; wp = 0; sel = 2'b10;
    hold(5);
    chk("R12 oe in reset", {31'd0, sda_oe}, 32'd0);
    rst_n = 1; hold(5);
    chk("R12 oe after reset", {31'd0, sda_oe}, 32'd0);

    // R12/R2: first command after reset, two-byte page write to 0x000
    write_seq(9'h000, 2, 32'h5566_0000, acks);
    chk("R12 R2 acks after reset", {26'd0, acks}, 32'h0F);

    // R4: control bytes refused while busy
    i2c_start; send_byte(ctrl(1'b0, 1'b1), k); i2c_stop;
    chk("R4 read ctrl while busy", {31'd0, k}, 32'd0);
    i2c_start; send_byte(ctrl(1'b0, 1'b0), k); i2c_stop;
    chk("R4 write ctrl while busy", {31'd0, k}, 32'd0);
    poll(tries);
    chk("R5 poll ends", {31'd0, tries < 40}, 32'd1);

    // R1: mismatching select bits and device code
    i2c_start; send_byte({4'b1010, 2'b01, 2'b00}, k); i2c_stop;
    chk("R1 select mismatch", {31'd0, k}, 32'd0);
    i2c_start; send_byte({4'b1011, 2'b10, 2'b00}, k); i2c_stop;
    chk("R1 code mismatch", {31'd0, k}, 32'd0);

    // table: single-byte write, poll, random read back
    for (int v = 0; v < 6; v++) begin
      write_seq(VEC[v][16:8], 1, {VEC[v][7:0], 24'd0}, acks);
      chk("R2 table acks", {26'd0, acks}, 32'h07);
      poll(tries);
      chk("R4 table first poll refused", {31'd0, tries > 0}, 32'd1);
      read_seq(VEC[v][16:8], 1, d);
      chk("R9 R5 table readback", {24'd0, d[31:24]}, {24'd0, VEC[v][7:0]});
    end

    // R6: write wraps within the page
    write_seq(9'h01E, 4, 32'h1122_3344, acks);
    chk("R6 acks", {26'd0, acks}, 32'h3F);
    poll(tries);
    read_seq(9'h01E, 2, d);
    chk("R10 sequential 0x01E", d[31:16], 32'h1122);
    read_seq(9'h010, 2, d);
    chk("R6 wrapped to page start", d[31:16], 32'h3344);
    chk("R10 oe released after nack", {31'd0, sda_oe}, 32'd0);

    // R3: repeated start after write data discards it
    i2c_start;
    send_byte(ctrl(1'b0, 1'b0), k); send_byte(8'h10, k); send_byte(8'hEE, k);
    i2c_start;
    send_byte(ctrl(1'b0, 1'b0), k); send_byte(8'h10, k);
    i2c_start;
    send_byte(ctrl(1'b0, 1'b1), k); read_byte(1'b0, b);
    i2c_stop;
    chk("R3 no commit before stop", {24'd0, b}, 32'h33);
    i2c_start; send_byte(ctrl(1'b0, 1'b0), k); i2c_stop;
    chk("R3 no busy after discard", {31'd0, k}, 32'd1);
    read_seq(9'h010, 1, d);
    chk("R3 contents kept", {24'd0, d[31:24]}, 32'h33);

    // R7/R8: read wrap and current address
    write_seq(9'h1FF, 1, 32'hA500_0000, acks);
    poll(tries);
    read_seq(9'h1FF, 2, d);
    chk("R7 read wrap 511 to 0", d[31:16], 32'hA555);
    i2c_start; send_byte(ctrl(1'b0, 1'b1), k); read_byte(1'b0, b); i2c_stop;
    chk("R8 current address read", {24'd0, b}, 32'h66);

    // R11: write protect
    wp = 1;
    write_seq(9'h000, 1, 32'h9900_0000, acks);
    chk("R11 acks under protect", {26'd0, acks}, 32'h07);
    i2c_start; send_byte(ctrl(1'b0, 1'b0), k); i2c_stop;
    chk("R11 no busy", {31'd0, k}, 32'd1);
    read_seq(9'h000, 1, d);
    chk("R11 not committed", {24'd0, d[31:24]}, 32'h55);
    wp = 0;

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule